// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block lets any of 2 to 4 processors interrupt any set of processors, itself included, with a single register write. A shared trigger window takes one write. That write carries a doorbell number and a bitmap of target processors. Every named processor latches the doorbell as pending.

Each processor also has a private window with two registers:
- a pending-doorbell register, which software clears by writing an AND mask;
- an enable register.

The unit drives one summary request line per processor. The line is high while at least one pending doorbell of that processor is also enabled. The line feeds the lowest-numbered input of the system interrupt controller.

The design has no sequential control beyond its registers. Each per-processor bank has two decoded write kinds, selected through an enumerated register-kind type with a unique case: a pending write (kind `DB_REG_PEND`) and an enable write (kind `DB_REG_ENAB`). A shared-window write of kind `DB_REG_TRIG` fans out through the trigger decoder. Any other address decodes to `DB_REG_NONE` and changes no register.

Top module: `ipi_doorbell_unit`

## Requirements
- R1: After reset every pending register reads 0, every enable register reads 0, and every summary request output is low.
- R2: A shared-window write at byte offset 0x4 takes the doorbell number from data bits [7:0] and the target bitmap from bits [8+k] for processor k. It sets bit `number` in the pending register of every targeted processor on the same clock edge.
- R3: A trigger whose doorbell number is 8 or greater changes no pending register.
- R4: Target bits at positions 8+NUM_CPUS and above are ignored. A shared-window write at any offset other than 0x4 changes no pending register.
- R5: A private-window write at offset 0x8 ANDs data bits [7:0] into that processor's pending bits, so writing 0 clears them all. Other processors are untouched.
- R6: When a trigger sets a bit in the same cycle that a pending-register write would clear it, the bit ends up set.
- R7: A private-window write at offset 0xC loads data bits [7:0] into that processor's enable register. A 1 enables the matching doorbell.
- R8: Summary request k is high exactly when pending[k] AND enable[k] is non-zero. It follows the registers with no added delay.
- R9: A read at private offset 0x8 returns the pending bits and a read at 0xC returns the enable bits, both zero-extended. Any other private offset reads 0.
- R10: Pending bits accumulate. Triggers with different numbers OR together, and re-triggering a set bit leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sh_we | input | 1 | Shared-window write strobe |
| sh_addr | input | 4 | Shared-window byte offset |
| sh_wdata | input | 32 | Shared-window write data |
| pv_we | input | 1 | Private-window write strobe |
| pv_cpu | input | 2 | Processor whose private window is written |
| pv_addr | input | 4 | Private-window write byte offset |
| pv_wdata | input | 32 | Private-window write data |
| rd_cpu | input | 2 | Processor whose private window is read |
| rd_addr | input | 4 | Private-window read byte offset |
| rd_data | output | 32 | Read data, combinational |
| db_req | output | 4 | Summary doorbell request, one per processor |

## Verification
Both write windows update their registers on the clock edge that samples the strobe. Read data and the summary requests are combinational from those registers. Every result is therefore due in the cycle right after the write edge.

The bench drives stimulus on the falling edge. It waits for the next rising edge and then updates its reference model. It samples the read port and the request lines a fraction of a nanosecond later, well before the next falling edge. Same-cycle collisions of trigger and clear are driven on a single edge, so the precedence rule is observed directly.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam logic [3:0] OFF_TRIG = 4'h4;
    localparam logic [3:0] OFF_PEND = 4'h8;
    localparam logic [3:0] OFF_ENAB = 4'hC;
    localparam int         IDX_W    = 8;
    localparam int         TGT_LSB  = 8;

    typedef enum logic [1:0] {
        DB_REG_NONE,
        DB_REG_TRIG,
        DB_REG_PEND,
        DB_REG_ENAB
    } db_reg_e;

    function automatic db_reg_e decode_shared(input logic [3:0] off);
        return (off == OFF_TRIG) ? DB_REG_TRIG : DB_REG_NONE;
    endfunction

    function automatic db_reg_e decode_private(input logic [3:0] off);
        db_reg_e k;
        unique case (off)
            OFF_PEND: k = DB_REG_PEND;
            OFF_ENAB: k = DB_REG_ENAB;
            default:  k = DB_REG_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dbell_trigger_decode.sv
module dbell_trigger_decode
    import dbell_pkg::*;
#(
    parameter int NUM_CPUS  = 4,
    parameter int NUM_BELLS = 8,
    parameter int DATA_W    = 32
) (
    input  logic                 we,
    input  logic [3:0]           addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_CPUS-1:0]  hit_cpu,
    output logic [NUM_BELLS-1:0] hit_bell
);

    logic [IDX_W-1:0] idx;
    logic             fire;

    always_comb begin
        idx  = wdata[IDX_W-1:0];
        fire = we && (decode_shared(addr) == DB_REG_TRIG) && (int'(idx) < NUM_BELLS);
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_tgt
        always_comb hit_cpu[c] = fire && wdata[TGT_LSB + c];
    end

    for (genvar b = 0; b < NUM_BELLS; b++) begin : g_bell
        always_comb hit_bell[b] = fire && (int'(idx) == b);
    end

endmodule

// File: rtl/dbell_cpu_bank.sv
module dbell_cpu_bank
    import dbell_pkg::*;
#(
    parameter int NUM_BELLS = 8,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BELLS-1:0] set_bits,
    input  logic                 wr_en,
    input  db_reg_e              wr_kind,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_BELLS-1:0] pend_q,
    output logic [NUM_BELLS-1:0] enab_q,
    output logic                 req
);

    logic [NUM_BELLS-1:0] pend_d;
    logic [NUM_BELLS-1:0] enab_d;

    always_comb begin
        pend_d = pend_q;
        enab_d = enab_q;
        if (wr_en) begin
            unique case (wr_kind)
                DB_REG_PEND: pend_d = pend_q & wr_data[NUM_BELLS-1:0];
                DB_REG_ENAB: enab_d = wr_data[NUM_BELLS-1:0];
                default:     ;
            endcase
        end
        pend_d = pend_d | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            enab_q <= '0;
        end else begin
            pend_q <= pend_d;
            enab_q <= enab_d;
        end
    end

    always_comb req = |(pend_q & enab_q);

    a_r6_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((pend_q & $past(set_bits)) == $past(set_bits)));

    a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == DB_REG_PEND && wr_data[NUM_BELLS-1:0] == '0 && set_bits == '0)
        |=> (pend_q == '0));

    a_r7_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == DB_REG_ENAB) |=> (enab_q == $past(wr_data[NUM_BELLS-1:0])));

    a_r8_no_req_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (enab_q == '0) |-> !req);

endmodule

// File: rtl/ipi_doorbell_unit.sv
module ipi_doorbell_unit
    import dbell_pkg::*;
#(
    parameter int NUM_CPUS  = 4,
    parameter int NUM_BELLS = 8,
    parameter int DATA_W    = 32,
    localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sh_we,
    input  logic [3:0]          sh_addr,
    input  logic [DATA_W-1:0]   sh_wdata,
    input  logic                pv_we,
    input  logic [CPU_W-1:0]    pv_cpu,
    input  logic [3:0]          pv_addr,
    input  logic [DATA_W-1:0]   pv_wdata,
    input  logic [CPU_W-1:0]    rd_cpu,
    input  logic [3:0]          rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_CPUS-1:0] db_req
);

    logic [NUM_CPUS-1:0]  hit_cpu;
    logic [NUM_BELLS-1:0] hit_bell;
    logic [NUM_BELLS-1:0] pend_all [NUM_CPUS];
    logic [NUM_BELLS-1:0] enab_all [NUM_CPUS];
    logic [NUM_CPUS*NUM_BELLS-1:0] pend_flat;
    db_reg_e              pv_kind;

    always_comb pv_kind = decode_private(pv_addr);

    dbell_trigger_decode #(
        .NUM_CPUS (NUM_CPUS),
        .NUM_BELLS(NUM_BELLS),
        .DATA_W   (DATA_W)
    ) u_trig (
        .we      (sh_we),
        .addr    (sh_addr),
        .wdata   (sh_wdata),
        .hit_cpu (hit_cpu),
        .hit_bell(hit_bell)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
        logic [NUM_BELLS-1:0] set_bits;
        logic                 sel;
        always_comb set_bits = hit_cpu[c] ? hit_bell : '0;
        always_comb sel      = pv_we && (int'(pv_cpu) == c);

        dbell_cpu_bank #(
            .NUM_BELLS(NUM_BELLS),
            .DATA_W   (DATA_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_bits(set_bits),
            .wr_en   (sel),
            .wr_kind (pv_kind),
            .wr_data (pv_wdata),
            .pend_q  (pend_all[c]),
            .enab_q  (enab_all[c]),
            .req     (db_req[c])
        );

        always_comb pend_flat[c*NUM_BELLS +: NUM_BELLS] = pend_all[c];
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_cpu) < NUM_CPUS) begin
            unique case (decode_private(rd_addr))
                DB_REG_PEND: rd_data[NUM_BELLS-1:0] = pend_all[rd_cpu];
                DB_REG_ENAB: rd_data[NUM_BELLS-1:0] = enab_all[rd_cpu];
                default:     rd_data = '0;
            endcase
        end
    end

    a_r3_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_we && sh_addr == OFF_TRIG && int'(sh_wdata[IDX_W-1:0]) >= NUM_BELLS && !pv_we)
        |=> $stable(pend_flat));

    a_r4_other_offset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_we && sh_addr != OFF_TRIG && !pv_we) |=> $stable(pend_flat));

endmodule

// File: tb/ipi_doorbell_unit_bench.sv
`timescale 1ns/100ps
module ipi_doorbell_unit_bench;

    localparam int NC = 4;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sh_we, pv_we;
    logic [3:0]  sh_addr, pv_addr, rd_addr;
    logic [31:0] sh_wdata, pv_wdata, rd_data;
    logic [1:0]  pv_cpu, rd_cpu;
    logic [3:0]  db_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_pend [NC];
    logic [7:0] m_enab [NC];

    always #5 clk = ~clk;

    ipi_doorbell_unit u_ipi_doorbell_unit (
        .clk(clk), .rst_n(rst_n),
        .sh_we(sh_we), .sh_addr(sh_addr), .sh_wdata(sh_wdata),
        .pv_we(pv_we), .pv_cpu(pv_cpu), .pv_addr(pv_addr), .pv_wdata(pv_wdata),
        .rd_cpu(rd_cpu), .rd_addr(rd_addr), .rd_data(rd_data),
        .db_req(db_req)
    );

    function automatic logic exp_req(input logic [7:0] p, input logic [7:0] e);
        return |(p & e);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input int c, input logic [3:0] off,
                            input logic [31:0] exp);
        rd_cpu  = 2'(c);
        rd_addr = off;
        #0.1;
        check(tag, rd_data, exp);
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NC; c++) begin
            read_chk({tag, " pending"}, c, 4'h8, {24'h0, m_pend[c]});
            read_chk({tag, " enable"},  c, 4'hC, {24'h0, m_enab[c]});
            check({tag, " R8 request"}, {31'h0, db_req[c]},
                  {31'h0, exp_req(m_pend[c], m_enab[c])});
        end
    endtask

    task automatic step(input string tag,
                        input logic s_we, input logic [3:0] s_a, input logic [31:0] s_d,
                        input logic p_we, input int p_c, input logic [3:0] p_a,
                        input logic [31:0] p_d);
        @(negedge clk);
        sh_we = s_we; sh_addr = s_a; sh_wdata = s_d;
        pv_we = p_we; pv_cpu = 2'(p_c); pv_addr = p_a; pv_wdata = p_d;
        @(posedge clk);
        #0.5;
        if (p_we && p_a == 4'h8) m_pend[p_c] = m_pend[p_c] & p_d[7:0];
        if (p_we && p_a == 4'hC) m_enab[p_c] = p_d[7:0];
        if (s_we && s_a == 4'h4 && s_d[7:0] < NB)
            for (int c = 0; c < NC; c++)
                if (s_d[8+c]) m_pend[c] = m_pend[c] | (8'h1 << s_d[7:0]);
        sh_we = 1'b0; pv_we = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        sh_we = 0; sh_addr = 0; sh_wdata = 0;
        pv_we = 0; pv_cpu = 0; pv_addr = 0; pv_wdata = 0;
        rd_cpu = 0; rd_addr = 0;
        for (int c = 0; c < NC; c++) begin m_pend[c] = 0; m_enab[c] = 0; end
        repeat (3) @(posedge clk);
        #0.5;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        step("R7 enable all", 0, 4'h0, 0, 1, 0, 4'hC, 32'hFF);
        step("R7 enable cpu2", 0, 4'h0, 0, 1, 2, 4'hC, 32'hA5);
        step("R2 bell3 to cpu0,2", 1, 4'h4, 32'h0000_0503, 0, 0, 4'h0, 0);
        step("R10 bell6 to cpu0", 1, 4'h4, 32'h0000_0106, 0, 0, 4'h0, 0);
        step("R10 bell3 again cpu0", 1, 4'h4, 32'h0000_0103, 0, 0, 4'h0, 0);
        step("R2 broadcast bell0", 1, 4'h4, 32'h0000_0F00, 0, 0, 4'h0, 0);
        step("R3 index 8", 1, 4'h4, 32'h0000_0F08, 0, 0, 4'h0, 0);
        step("R3 index 200", 1, 4'h4, 32'h0000_0FC8, 0, 0, 4'h0, 0);
        step("R4 high targets only", 1, 4'h4, 32'hFFFF_F005, 0, 0, 4'h0, 0);
        step("R4 other offset", 1, 4'h0, 32'h0000_0F02, 0, 0, 4'h0, 0);
        step("R5 and-mask cpu0", 0, 4'h0, 0, 1, 0, 4'h8, 32'hF0);
        step("R5 zero clears cpu2", 0, 4'h0, 0, 1, 2, 4'h8, 32'h0);
        step("R6 trigger wins", 1, 4'h4, 32'h0000_0204, 1, 1, 4'h8, 32'h0);
        read_chk("R9 unmapped offset", 1, 4'h4, 32'h0);
        read_chk("R9 unmapped offset 0", 0, 4'h0, 32'h0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] sd, pd;
            logic [3:0]  sa, pa;
            sd = {$urandom} & 32'hFFFF_FF00;
            sd[7:0] = ($urandom % 6 == 0) ? 8'(8 + $urandom % 248) : 8'($urandom % 8);
            sa = ($urandom % 8 == 0) ? 4'($urandom) : 4'h4;
            case ($urandom % 4)
                0: pa = 4'hC;
                1, 2: pa = 4'h8;
                default: pa = 4'($urandom);
            endcase
            pd = $urandom;
            step("R2/R5/R6/R10 random", 1'($urandom % 2), sa, sd,
                 1'($urandom % 2), int'($urandom % NC), pa, pd);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule